// File: doc/BRIEF.md
# Serial token and frame-marker packet builder

This block turns one request into a 24-bit serial packet of the kind a full-speed serial bus host sends to open a transaction or mark a frame. The caller picks one of four packet kinds, supplies a 7-bit device address and a 4-bit endpoint number, or an 11-bit frame count, and pulses a request. The block then emits the packet one bit per clock.

Each packet starts with an identifier byte. The identifier's upper nibble is the complement of its lower nibble, so a receiver can check it. Next come 11 payload bits. The packet ends with a 5-bit check code computed over the payload only.

A bit-valid strobe frames the packet, and a final-bit flag marks its last cycle. The block is intended to feed a line encoder, which is outside this block and handles inversion coding and bit insertion. The caller may start a new packet once the bit-valid strobe is low.

Top module: `usb_tok_gen`

## Requirements
- R1: `kind_i` selects the identifier byte: 0 gives 8'hE1, 1 gives 8'h69, 2 gives 8'h2D and 3 (frame marker) gives 8'hA5. The upper nibble is always the bitwise complement of the lower nibble.
- R2: Bits leave in this order. First the identifier, least significant bit first (packet bits 0..7). For kinds 0 to 2, the address follows, LSB first (bits 8..14), then the endpoint, LSB first (bits 15..18).
- R3: For kind 3, the 11-bit frame count takes packet bits 8..18, LSB first.
- R4: Packet bits 19..23 carry the check code. It is computed over packet bits 8..18 in send order with generator x^5+x^2+1 and a register preset to 5'b11111. The remainder is inverted and sent most significant bit first.
- R5: When `req_i` is high at a rising edge and `bit_valid_o` is low, the request is accepted. `bit_valid_o` rises in the next cycle, carrying packet bit 0, and stays high for exactly 24 consecutive cycles.
- R6: `last_o` is high only together with packet bit 23. In the cycle after it, `bit_valid_o` is low, even if `req_i` was high during the last bit.
- R7: A request made while `bit_valid_o` is high is ignored and does not alter the packet in flight.
- R8: The kind, address, endpoint and frame inputs are captured at acceptance. Later changes do not affect the packet in flight.
- R9: While `rst_ni` is low, and after reset, `bit_valid_o` and `last_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start request, taken only when idle |
| kind_i | input | 2 | Packet kind: 0, 1, 2 token kinds, 3 frame marker |
| addr_i | input | 7 | Device address |
| endp_i | input | 4 | Endpoint number |
| frame_i | input | 11 | Frame count |
| bit_o | output | 1 | Serial packet bit |
| bit_valid_o | output | 1 | High while `bit_o` carries a packet bit |
| last_o | output | 1 | High with the final packet bit |

## Verification
The bench covers several corner cases:
- All-zero and all-one payloads, which expose a wrong preset or a missing final inversion in the check code. A design that got either wrong would produce a wrong tail.
- Asymmetric payloads, which catch a reversed field or a code sent LSB first. A design that swapped the order of the address and endpoint, or the order of the code bits, would emit a scrambled packet.
- A request pulsed in mid-packet. A block that restarted on it would cut the packet short or reload the payload.
- Inputs changed after acceptance. A block that did not capture its inputs would mix the fields of two packets.
- A request held during the final bit. A block that accepted it at that edge would show no idle cycle after the last bit.

// File: rtl/usb_tok_pkg.sv
package usb_tok_pkg;
  localparam int PID_W   = 8;
  localparam int ADDR_W  = 7;
  localparam int ENDP_W  = 4;
  localparam int FIELD_W = ADDR_W + ENDP_W;
  localparam int CRC_W   = 5;
  localparam int PKT_W   = PID_W + FIELD_W + CRC_W;
  localparam int CNT_W   = $clog2(PKT_W);
  localparam int CRC_START = PID_W + FIELD_W;

  typedef enum logic [1:0] {
    KIND_OUT   = 2'd0,
    KIND_IN    = 2'd1,
    KIND_SETUP = 2'd2,
    KIND_SOF   = 2'd3
  } kind_e;

  function automatic logic [PID_W-1:0] pid_of(kind_e k);
    logic [3:0] t;
    case (k)
      KIND_OUT:   t = 4'h1;
      KIND_IN:    t = 4'h9;
      KIND_SETUP: t = 4'hD;
      default:    t = 4'h5;
    endcase
    return {~t, t};
  endfunction
endpackage

// File: rtl/usb_tok_crc5.sv
module usb_tok_crc5 #(
  parameter int         W    = 5,
  parameter logic [W-1:0] POLY = 5'h05,
  parameter logic [W-1:0] INIT = 5'h1F
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         init_i,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] crc_o
);
  logic fb;
  assign fb = bit_i ^ crc_o[W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_o <= INIT;
    else if (init_i) crc_o <= INIT;
    else if (en_i)   crc_o <= {crc_o[W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end
endmodule

// File: rtl/usb_tok_seq.sv
module usb_tok_seq
  import usb_tok_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  output logic             accept_o,
  output logic             busy_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             field_o,
  output logic             last_o
);
  assign accept_o = req_i && !busy_o;
  assign last_o   = busy_o && (cnt_o == CNT_W'(PKT_W - 1));
  assign field_o  = busy_o && (cnt_o >= CNT_W'(PID_W)) && (cnt_o < CNT_W'(CRC_START));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      cnt_o  <= '0;
    end else if (accept_o) begin
      busy_o <= 1'b1;
      cnt_o  <= '0;
    end else if (last_o) begin
      busy_o <= 1'b0;
      cnt_o  <= '0;
    end else if (busy_o) begin
      cnt_o  <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/usb_tok_gen.sv
module usb_tok_gen
  import usb_tok_pkg::*;
#(
  parameter logic [CRC_W-1:0] CRC_POLY = 5'h05,
  parameter logic [CRC_W-1:0] CRC_INIT = 5'h1F
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic [1:0]         kind_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [ENDP_W-1:0]  endp_i,
  input  logic [FIELD_W-1:0] frame_i,
  output logic               bit_o,
  output logic               bit_valid_o,
  output logic               last_o
);
  localparam int SH_W = PID_W + FIELD_W;

  logic             accept, busy, field_en;
  logic [CNT_W-1:0] cnt;
  logic [SH_W-1:0]  sh_q;
  logic [CRC_W-1:0] crc;
  logic [FIELD_W-1:0] field_d;
  logic [CNT_W-1:0] crc_idx;

  usb_tok_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .accept_o (accept),
    .busy_o   (busy),
    .cnt_o    (cnt),
    .field_o  (field_en),
    .last_o   (last_o)
  );

  // Frame marker replaces address+endpoint with the frame count
  assign field_d = (kind_e'(kind_i) == KIND_SOF) ? frame_i : {endp_i, addr_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sh_q <= '0;
    else if (accept) sh_q <= {field_d, pid_of(kind_e'(kind_i))};
    else if (busy)   sh_q <= sh_q >> 1;
  end

  usb_tok_crc5 #(.W(CRC_W), .POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .init_i (accept),
    .en_i   (field_en),
    .bit_i  (sh_q[0]),
    .crc_o  (crc)
  );

  assign crc_idx     = CNT_W'(PKT_W - 1) - cnt;
  assign bit_valid_o = busy;

  always_comb begin
    if (!busy)                           bit_o = 1'b0;
    else if (cnt < CNT_W'(CRC_START))    bit_o = sh_q[0];
    else                                 bit_o = ~crc[crc_idx[$clog2(CRC_W)-1:0]];
  end
endmodule

// File: rtl/usb_tok_gen_chk.sv
module usb_tok_gen_chk
  import usb_tok_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input logic req_i,
  input logic bit_valid_o,
  input logic last_o
);
  logic [CNT_W-1:0] seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          seen <= '0;
    else if (bit_valid_o) seen <= seen + 1'b1;
    else                  seen <= '0;
  end

  p_accept_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !bit_valid_o) |=> bit_valid_o);

  p_contiguous_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_valid_o && !last_o) |=> bit_valid_o);

  p_last_pos_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> (bit_valid_o && seen == CNT_W'(PKT_W - 1)));

  p_idle_after_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> !bit_valid_o);

  p_full_len_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_valid_o && seen == CNT_W'(PKT_W - 1)) |-> last_o);

  always_comb begin
    if (!rst_ni) p_reset_r9: assert (!last_o || bit_valid_o);
  end
endmodule

bind usb_tok_gen usb_tok_gen_chk u_chk (.*);

// File: tb/usb_tok_gen_test.sv
module usb_tok_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [1:0]  kind = '0;
  logic [6:0]  addr = '0;
  logic [3:0]  endp = '0;
  logic [10:0] frame = '0;
  logic        bit_s, vld, last;
  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  usb_tok_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .kind_i(kind),
    .addr_i(addr), .endp_i(endp), .frame_i(frame),
    .bit_o(bit_s), .bit_valid_o(vld), .last_o(last)
  );

  // {kind, addr, endp, frame}
  localparam logic [23:0] VEC [8] = '{
    {2'd0, 7'h00, 4'h0, 11'h000},
    {2'd1, 7'h7F, 4'hF, 11'h000},
    {2'd2, 7'h15, 4'hE, 11'h000},
    {2'd3, 7'h00, 4'h0, 11'h000},
    {2'd3, 7'h00, 4'h0, 11'h7FF},
    {2'd3, 7'h00, 4'h0, 11'h5A3},
    {2'd0, 7'h3A, 4'h1, 11'h000},
    {2'd1, 7'h01, 4'h8, 11'h000}
  };

  function automatic logic [23:0] expect_pkt(logic [1:0] k, logic [6:0] a,
                                             logic [3:0] e, logic [10:0] f);
    logic [7:0]  pid;
    logic [10:0] fld;
    logic [4:0]  c;
    logic [23:0] s;
    case (k)
      2'd0: pid = 8'hE1;
      2'd1: pid = 8'h69;
      2'd2: pid = 8'h2D;
      default: pid = 8'hA5;
    endcase
    fld = (k == 2'd3) ? f : {e, a};
    c = 5'h1F;
    for (int j = 0; j < 11; j++) begin
      logic msb;
      msb = c[4];
      c = {c[3:0], 1'b0};
      if (fld[j] ^ msb) c = c ^ 5'b00101;
    end
    for (int i = 0; i < 8; i++)  s[i] = pid[i];
    for (int j = 0; j < 11; j++) s[8+j] = fld[j];
    for (int k2 = 0; k2 < 5; k2++) s[19+k2] = ~c[4-k2];
    return s;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [23:0] act,
                     input logic [23:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // mode 0 plain, 1 req pulse mid-packet, 2 inputs change after accept, 3 req held at last bit
  task automatic run(input logic [1:0] k, input logic [6:0] a, input logic [3:0] e,
                     input logic [10:0] f, input int mode, input string tag);
    logic [23:0] exp, got;
    int bad_last, bad_vld;
    exp = expect_pkt(k, a, e, f);
    got = '0; bad_last = 0; bad_vld = 0;
    @(negedge clk);
    kind = k; addr = a; endp = e; frame = f; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    for (int i = 0; i < 24; i++) begin
      if (i > 0) @(negedge clk);
      got[i] = bit_s;
      if (!vld) bad_vld++;
      if (last !== (i == 23)) bad_last++;
      if (mode == 1 && i == 5) begin
        req = 1'b1; kind = ~k; addr = ~a; endp = ~e; frame = ~f;
      end
      if (mode == 1 && i == 6) req = 1'b0;
      if (mode == 2 && i == 3) begin
        kind = ~k; addr = ~a; endp = ~e; frame = ~f;
      end
      if (mode == 3 && i == 23) req = 1'b1;
    end
    chk(got == exp, {tag, " R1 R2 R3 R4 packet"}, got, exp);
    chk(bad_vld == 0, {tag, " R5 valid run"}, 24'(bad_vld), 24'd0);
    chk(bad_last == 0, {tag, " R6 last position"}, 24'(bad_last), 24'd0);
    @(negedge clk);
    chk(!vld && !last, {tag, " R6 idle after last"}, {22'd0, vld, last}, 24'd0);
    req = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL R5 watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1;
    chk(!vld && !last, "R9 during reset", {22'd0, vld, last}, 24'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!vld && !last, "R9 after reset", {22'd0, vld, last}, 24'd0);

    foreach (VEC[v])
      run(VEC[v][23:22], VEC[v][21:15], VEC[v][14:11], VEC[v][10:0], 0, "vec");

    run(2'd2, 7'h55, 4'hA, 11'h000, 1, "R7 req while busy");
    run(2'd0, 7'h0C, 4'h3, 11'h000, 2, "R8 inputs after accept");
    run(2'd3, 7'h00, 4'h0, 11'h2B4, 2, "R8 frame after accept");
    run(2'd1, 7'h42, 4'h5, 11'h000, 3, "R6 req at last bit");

    // idle with no request stays quiet
    repeat (4) @(negedge clk);
    chk(!vld && !last, "R5 no request no output", {22'd0, vld, last}, 24'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule